// File: doc/BRIEF.md
# DDR2 Posted-Write Burst Launcher

This block sits in a DDR2 controller's write path, between the command scheduler and the data pins. The scheduler hands it a posted write command together with all of that write's data beats in a single cycle. The block queues the write. When the write latency has elapsed, it plays the beats out as a double-data-rate burst: one beat on the rising half of a clock and the next beat on the falling half. The write latency is the additive latency plus the CAS latency minus one.

The strobe is modelled as a pair of levels per clock, one for each half, plus an output-enable.
- One clock before a burst, the strobe is driven low as a preamble.
- During a burst it toggles high then low in every clock, in step with the data.
- When two writes are spaced exactly one burst apart (two clocks for four beats, four clocks for eight), their data runs back to back. There is no idle clock and no second preamble between them. This holds whether the two writes target the same bank or different banks, so the block carries no bank information.
- If a write's due time passes while an earlier burst still occupies the pins (illegal spacing from the scheduler), the late write starts right after that burst.
- A write that finds the queue full is dropped and flagged.

The write latency must be at least three clocks (additive latency plus CAS latency of four or more) so that the preamble clock exists.

Top module: `wrburst_launcher`

The controlling state machine has three states:
- IDLE: pins quiet.
- PRE: preamble clock.
- BURST: beats on the pins, with a beat-pair counter.

Its transitions are:
- arm: IDLE to PRE, when the queue head is due within two clocks.
- launch: PRE to BURST, which pops the head.
- step: BURST to BURST, on a clock that is not the last of the burst.
- chain: BURST to BURST on the last clock, when the next head is due in the following clock or overdue. This pops the head.
- rearm: BURST to PRE on the last clock, when the next head is due in exactly two clocks.
- finish: BURST to IDLE on the last clock, otherwise.

## Requirements
- R1: While reset is asserted and in the first cycle after it, dq_valid, dqs_oe, dqs_rise, dqs_fall and overflow are all 0.
- R2: A write accepted with wr_valid at the rising edge ending cycle c, with no earlier burst in the way, puts its first beat on the pins in cycle c + ADD_LAT + CAS_LAT - 1.
- R3: In the k-th clock of a burst (k from 0), dq_rise carries beat 2k and dq_fall carries beat 2k+1. Beat i is taken from wr_data[i*DATA_W +: DATA_W].
- R4: With wr_bl8=1 the burst lasts 4 clocks (beats 0..7). With wr_bl8=0 it lasts 2 clocks (beats 0..3), and bits of wr_data above beat 3 have no effect.
- R5: A write accepted exactly as many clocks after the previous one as that previous burst lasts makes dq_valid stay high across the boundary. The new burst's beats directly follow the old one's, with no preamble clock between.
- R6: In the cycle before a burst that does not directly follow another burst, dqs_oe is 1 with dqs_rise=0 and dqs_fall=0 (preamble). A spacing one clock longer than the previous burst gives exactly one such clock between the two bursts.
- R7: In every clock with dq_valid=1, dqs_oe=1, dqs_rise=1 and dqs_fall=0.
- R8: When no burst or preamble is scheduled, dq_valid=0, dqs_oe=0 and both strobe levels are 0.
- R9: A wr_valid seen when QDEPTH writes are pending is dropped: overflow is 1 in the next cycle only, and the pins carry only the accepted writes. A write stays pending from acceptance up to the cycle before its burst starts.
- R10: A write whose due cycle is already taken by an earlier burst starts in the clock right after that burst ends, with no preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Posted write command with its data |
| wr_bl8 | input | 1 | 1: eight-beat burst, 0: four-beat burst |
| wr_data | input | 8*DATA_W | Write beats, beat i at bits i*DATA_W upward |
| dq_valid | output | 1 | A beat pair is on the pins this clock |
| dq_rise | output | DATA_W | Beat sent on the rising half |
| dq_fall | output | DATA_W | Beat sent on the falling half |
| dqs_oe | output | 1 | Strobe driven this clock |
| dqs_rise | output | 1 | Strobe level in the rising half |
| dqs_fall | output | 1 | Strobe level in the falling half |
| overflow | output | 1 | One-cycle pulse: previous command dropped |

## Verification
The bench goes after the following corner cases:
- Exact-spacing chains of four- and eight-beat writes, mixed. A design that inserts a preamble there leaves a hole in dq_valid.
- One-clock gaps. A design that forgets the rearm path loses the preamble and starts a burst with no preceding strobe low.
- Bursts of commands on consecutive clocks. These fill the queue and push due times past the burst in flight. A stale queue head would hang the pins or drop data, and a wrong full threshold would move or miss the overflow pulse.
- Four-beat writes whose upper data bits are random. These expose a burst length that reads the wrong field.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    // Pin-side sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_BURST = 2'd2
    } wrb_state_e;

    // Beats carried by one command (largest burst)
    localparam int MAX_BEATS = 8;

endpackage

// File: rtl/wrb_queue.sv
module wrb_queue #(
    parameter int DEPTH = 3,
    parameter int EW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop,
    input  logic [EW-1:0] din,
    output logic [EW-1:0] head,
    output logic          head_vld,
    output logic          overflow
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [EW-1:0]   slots [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] fill;
    logic            full, push;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full     = (fill == CNTW'(DEPTH));
    assign push     = push_req && !full;
    assign head     = slots[rp];
    assign head_vld = (fill != '0);

    always_ff @(posedge clk) begin
        if (push) slots[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            fill     <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            fill     <= fill + CNTW'(push) - CNTW'(pop);
            overflow <= push_req && full;
        end
    end

endmodule

// File: rtl/wrb_sequencer.sv
module wrb_sequencer
    import wrb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CW     = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          head_vld,
    input  logic [CW-1:0]                 head_due,
    input  logic                          head_bl8,
    input  logic [MAX_BEATS*DATA_W-1:0]   head_data,
    output logic                          pop,
    output logic [CW-1:0]                 now,
    output logic                          dq_valid,
    output logic [DATA_W-1:0]             dq_rise,
    output logic [DATA_W-1:0]             dq_fall,
    output logic                          dqs_oe,
    output logic                          dqs_rise,
    output logic                          dqs_fall
);
    wrb_state_e                    st, st_nx;
    logic [1:0]                    pair, pair_nx;
    logic                          cur_bl8;
    logic [MAX_BEATS*DATA_W-1:0]   cur_data;
    logic signed [CW-1:0]          slack;
    logic                          last_pair, due_now, due_soon;
    logic [DATA_W-1:0]             beat_a [MAX_BEATS];

    // Clocks left until the queue head must be on the pins
    assign slack     = $signed(head_due - now);
    assign due_now   = head_vld && (slack <= $signed(CW'(1)));
    assign due_soon  = head_vld && (slack <= $signed(CW'(2)));
    assign last_pair = (pair == (cur_bl8 ? 2'd3 : 2'd1));

    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_beat
        assign beat_a[g] = cur_data[g*DATA_W +: DATA_W];
    end

    // Transition selection
    always_comb begin
        st_nx   = st;
        pair_nx = pair;
        pop     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (due_soon) st_nx = ST_PRE;                      // arm
            end
            ST_PRE: begin
                if (head_vld) begin                                // launch
                    st_nx   = ST_BURST;
                    pair_nx = 2'd0;
                    pop     = 1'b1;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            ST_BURST: begin
                if (!last_pair) begin                              // step
                    pair_nx = pair + 2'd1;
                end else if (due_now) begin                        // chain
                    pair_nx = 2'd0;
                    pop     = 1'b1;
                end else if (due_soon) begin                       // rearm
                    st_nx = ST_PRE;
                end else begin                                     // finish
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pair     <= '0;
            cur_bl8  <= 1'b0;
            cur_data <= '0;
            now      <= '0;
        end else begin
            st   <= st_nx;
            pair <= pair_nx;
            now  <= now + CW'(1);
            if (pop) begin
                cur_bl8  <= head_bl8;
                cur_data <= head_data;
            end
        end
    end

    // Pin outputs
    always_comb begin
        dq_valid = (st == ST_BURST);
        dqs_oe   = (st != ST_IDLE);
        dqs_rise = (st == ST_BURST);
        dqs_fall = 1'b0;
        dq_rise  = dq_valid ? beat_a[{pair, 1'b0}] : '0;
        dq_fall  = dq_valid ? beat_a[{pair, 1'b1}] : '0;
    end

endmodule

// File: rtl/wrburst_launcher.sv
module wrburst_launcher
    import wrb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADD_LAT = 2,
    parameter int CAS_LAT = 3,
    parameter int QDEPTH  = (ADD_LAT + CAS_LAT) / 2 + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid,
    input  logic                        wr_bl8,
    input  logic [MAX_BEATS*DATA_W-1:0] wr_data,
    output logic                        dq_valid,
    output logic [DATA_W-1:0]           dq_rise,
    output logic [DATA_W-1:0]           dq_fall,
    output logic                        dqs_oe,
    output logic                        dqs_rise,
    output logic                        dqs_fall,
    output logic                        overflow
);
    localparam int WL = ADD_LAT + CAS_LAT - 1;
    localparam int DW = MAX_BEATS * DATA_W;
    localparam int CW = $clog2(WL + 4 * QDEPTH + 2) + 1;
    localparam int EW = 1 + CW + DW;

    logic [CW-1:0] now, head_due;
    logic [EW-1:0] entry_in, entry_hd;
    logic          head_vld, head_bl8, pop;
    logic [DW-1:0] head_data;

    assign entry_in = {wr_bl8, now + CW'(WL), wr_data};
    assign {head_bl8, head_due, head_data} = entry_hd;

    wrb_queue #(.DEPTH(QDEPTH), .EW(EW)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_valid),
        .pop      (pop),
        .din      (entry_in),
        .head     (entry_hd),
        .head_vld (head_vld),
        .overflow (overflow)
    );

    wrb_sequencer #(.DATA_W(DATA_W), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_vld  (head_vld),
        .head_due  (head_due),
        .head_bl8  (head_bl8),
        .head_data (head_data),
        .pop       (pop),
        .now       (now),
        .dq_valid  (dq_valid),
        .dq_rise   (dq_rise),
        .dq_fall   (dq_fall),
        .dqs_oe    (dqs_oe),
        .dqs_rise  (dqs_rise),
        .dqs_fall  (dqs_fall)
    );

endmodule

// File: rtl/wrburst_launcher_chk.sv
module wrburst_launcher_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic dq_valid,
    input logic dqs_oe,
    input logic dqs_rise,
    input logic dqs_fall,
    input logic overflow
);
    AST_BEAT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (dqs_oe && dqs_rise && !dqs_fall)); // R7

    AST_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !dqs_oe |-> (!dq_valid && !dqs_rise && !dqs_fall)); // R8

    AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |-> ($past(dqs_oe) && !$past(dqs_rise) && !$past(dqs_fall))); // R6

    AST_BURST_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |=> dq_valid); // R4

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(wr_valid)); // R9

endmodule

bind wrburst_launcher wrburst_launcher_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .dq_valid (dq_valid),
    .dqs_oe   (dqs_oe),
    .dqs_rise (dqs_rise),
    .dqs_fall (dqs_fall),
    .overflow (overflow)
);

// File: tb/wrburst_launcher_bench.sv
module wrburst_launcher_bench;
    localparam int DATA_W = 8;
    localparam int AL     = 2;
    localparam int CL     = 3;
    localparam int WL     = AL + CL - 1;
    localparam int QD     = (AL + CL) / 2 + 1;
    localparam int NC     = 4096;
    localparam int NW     = 8 * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_valid, wr_bl8;
    logic [NW-1:0]     wr_data;
    logic              dq_valid, dqs_oe, dqs_rise, dqs_fall, overflow;
    logic [DATA_W-1:0] dq_rise, dq_fall;

    always #10 clk = ~clk;

    wrburst_launcher #(.DATA_W(DATA_W), .ADD_LAT(AL), .CAS_LAT(CL)) u_wrburst_launcher (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bl8(wr_bl8), .wr_data(wr_data),
        .dq_valid(dq_valid), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dqs_oe(dqs_oe), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall), .overflow(overflow)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    string tag = "R1";

    // Expected pin picture per cycle
    bit          e_v [NC], e_oe [NC], e_r [NC], e_ov [NC];
    logic [DATA_W-1:0] e_dr [NC], e_df [NC];
    int acc_c [NC], acc_l [NC];
    int nacc = 0, prev_end = -100;

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] mk(input logic [7:0] base);
        logic [NW-1:0] d;
        for (int i = 0; i < 8; i++) d[i*DATA_W +: DATA_W] = DATA_W'(base + 8'(i));
        return d;
    endfunction

    // Reference model for one command issued in cycle c
    task automatic model_cmd(int c, bit b8, logic [NW-1:0] d);
        int pend = 0, n, l;
        for (int i = 0; i < nacc; i++) if (acc_c[i] < c && acc_l[i] > c) pend++;
        if (pend >= QD) begin
            if (c + 1 < NC) e_ov[c+1] = 1;
            return;
        end
        n = b8 ? 4 : 2;
        l = (c + WL > prev_end) ? c + WL : prev_end;
        if (l != prev_end && l - 1 < NC) e_oe[l-1] = 1;
        for (int k = 0; k < n; k++) begin
            if (l + k < NC) begin
                e_v[l+k]  = 1;
                e_oe[l+k] = 1;
                e_r[l+k]  = 1;
                e_dr[l+k] = d[(2*k)*DATA_W +: DATA_W];
                e_df[l+k] = d[(2*k+1)*DATA_W +: DATA_W];
            end
        end
        prev_end = l + n;
        acc_c[nacc] = c;
        acc_l[nacc] = l;
        nacc++;
    endtask

    task automatic compare_now();
        chk("dq_valid", int'(dq_valid), int'(e_v[cyc]));
        chk("dqs_oe",   int'(dqs_oe),   int'(e_oe[cyc]));
        chk("dqs_rise", int'(dqs_rise), int'(e_r[cyc]));
        chk("dqs_fall", int'(dqs_fall), 0);
        chk("overflow", int'(overflow), int'(e_ov[cyc]));
        if (e_v[cyc]) begin
            chk("dq_rise", int'(dq_rise), int'(e_dr[cyc]));
            chk("dq_fall", int'(dq_fall), int'(e_df[cyc]));
        end
    endtask

    task automatic step(bit v, bit b8, logic [NW-1:0] d);
        @(negedge clk);
        compare_now();
        wr_valid = v;
        wr_bl8   = b8;
        wr_data  = d;
        if (v) model_cmd(cyc, b8, d);
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int gap;
        void'($urandom(32'd20240611));
        rst_n = 0; wr_valid = 0; wr_bl8 = 0; wr_data = '0;
        // R1: quiet during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("dq_valid", int'(dq_valid), 0);
            chk("dqs_oe", int'(dqs_oe), 0);
            chk("overflow", int'(overflow), 0);
        end
        rst_n = 1;
        idle(3);

        tag = "R2/R3";                       // single four-beat write
        step(1, 0, mk(8'h10));
        idle(10);

        tag = "R4";                          // eight beats, then four with noisy top
        step(1, 1, mk(8'h20));
        idle(12);
        step(1, 0, {32'hDEADBEEF, mk(8'h30)[31:0]});
        idle(10);

        tag = "R5";                          // seamless chains
        step(1, 0, mk(8'h40)); idle(1);
        step(1, 0, mk(8'h48)); idle(1);
        step(1, 0, mk(8'h50));
        idle(10);
        step(1, 1, mk(8'h60)); idle(3);
        step(1, 0, mk(8'h68)); idle(1);
        step(1, 1, mk(8'h70));
        idle(12);

        tag = "R6";                          // one-clock gap
        step(1, 0, mk(8'h80)); idle(2);
        step(1, 1, mk(8'h88)); idle(4);
        step(1, 0, mk(8'h90));
        idle(12);

        tag = "R9/R10";                      // commands on consecutive clocks
        for (int i = 0; i < 5; i++) step(1, 0, mk(8'hA0 + 8'(8 * i)));
        idle(25);

        tag = "R7/R8";                       // constrained random traffic
        while (cyc < NC - 60) begin
            bit b8 = 1'($urandom % 2);
            int r = int'($urandom % 16);
            logic [NW-1:0] d = {$urandom, $urandom};
            int n = b8 ? 4 : 2;
            if (r < 6)       gap = n;
            else if (r < 9)  gap = n + 1;
            else if (r < 14) gap = n + 2 + int'($urandom % 8);
            else             gap = 1;
            step(1, b8, d);
            idle(gap - 1);
        end
        idle(30);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule